// File: doc/BRIEF.md
# Stack Call and Return Sequencer

This block carries out the stack side of five control and data-movement operations on a byte-wide memory with 16-bit addresses: subroutine call, subroutine return, restart to a fixed low vector, register-pair push and register-pair pop. A controller hands it one command together with the current stack pointer, the address of the instruction after the current one, a register-pair value and a branch target. The block then performs one single-byte memory access per cycle and returns the new stack pointer, program counter and register pair, marked by a one-cycle done pulse.

The stack grows downward. Stores put the most significant byte just below the old stack pointer and the least significant byte below that. Loads take the least significant byte from the stack pointer itself and the most significant byte from the next address up. Deciding whether a conditional branch is taken, fetching instructions and the memory array are left to the surrounding logic. Memory read data is used in the same cycle the address is presented.

Top module: `stack_seq_unit`

## Requirements
- R1: After reset, busy, done, mem_we and mem_re are 0, and sp_out, pc_out and pair_out are 0.
- R2: Command code 1 (call) writes pc_in[15:8] to sp_in-1 in the first cycle after acceptance. It writes pc_in[7:0] to sp_in-2 in the next cycle. At done, pc_out equals target_in.
- R3: Command code 4 (push) writes pair_in[15:8] to sp_in-1 and then pair_in[7:0] to sp_in-2, with the same timing as R2. At done, pair_out equals pair_in and pc_out equals pc_in.
- R4: After call, restart or push, sp_out equals sp_in-2 modulo 65536.
- R5: Command code 2 (return) reads the low byte from sp_in in the first cycle after acceptance and the high byte from sp_in+1 in the next cycle. At done, pc_out holds {high, low}.
- R6: Command code 5 (pop) reads the bytes in the same order as R5. At done, pair_out holds {high, low} and pc_out equals pc_in.
- R7: After return or pop, sp_out equals sp_in+2 modulo 65536.
- R8: Command code 3 (restart) stores pc_in exactly as a call does. At done, pc_out equals cmd_vec*8, so cmd_vec 0..7 gives 0x0000..0x0038, and target_in is ignored.
- R9: busy is 1 exactly during the two access cycles, and accesses occur only then. done is 1 for exactly one cycle, the cycle after the last access, with busy 0. The outputs change only at that point and hold until the next done.
- R10: While busy is 1, cmd_valid and every command input are ignored. The running sequence completes with the values captured at acceptance, and no second sequence follows it.
- R11: Command codes 0, 6 and 7 are not accepted: no busy, no memory access and no done follow.
- R12: mem_we and mem_re are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; accepted when busy is 0 and the code is known |
| cmd_op | input | 3 | 1 call, 2 return, 3 restart, 4 push, 5 pop |
| cmd_vec | input | 3 | Restart vector index |
| sp_in | input | 16 | Stack pointer before the operation |
| pc_in | input | 16 | Address of the following instruction |
| pair_in | input | 16 | Register pair to push |
| target_in | input | 16 | Call destination |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle of mem_re |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Updated stack pointer |
| pc_out | output | 16 | Updated program counter |
| pair_out | output | 16 | Updated register pair |

## Verification
The bench sweeps every command over stack pointers at 0x0000, 0x0001, 0x0002, 0x8000 and 0xFFFF, where the address and pointer arithmetic wraps. A wrong borrow or carry at those points would produce an address in the wrong 64 KiB position or a stale upper byte. Round trips of push followed by pop, and of call followed by return, catch a swapped byte order, because a design that stored the low byte first would hand back a byte-reversed word. All eight restart vectors are compared with index*8, which exposes a shift of the wrong size. Commands held on the inputs during a running sequence, and the unused codes, test that the sequencer neither restarts part-way, nor picks up changed operands, nor runs a phantom sequence.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_CALL = 3'd1,
      OP_RET  = 3'd2,
      OP_RST  = 3'd3,
      OP_PUSH = 3'd4,
      OP_POP  = 3'd5
   } stk_op_e;

   // A command is accepted only for one of the five defined codes
   function automatic logic op_known(input logic [2:0] code);
      return (code >= 3'd1) && (code <= 3'd5);
   endfunction

   // Store-type commands move a word onto the stack (downward)
   function automatic logic op_stores(input stk_op_e op);
      return (op == OP_CALL) || (op == OP_RST) || (op == OP_PUSH);
   endfunction

endpackage

// File: rtl/stk_step_ctrl.sv
module stk_step_ctrl #(
   parameter int NBYTES = 2,
   parameter int STEP_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic [STEP_W-1:0] step,
   output logic              last,
   output logic              done
);

   logic              run_q;
   logic [STEP_W-1:0] step_q;
   logic              done_q;

   generate
      if (NBYTES < 1) begin : g_bad_nbytes
         $error("stk_step_ctrl: NBYTES must be at least 1");
      end
      if ((2 ** STEP_W) < NBYTES) begin : g_bad_step_w
         $error("stk_step_ctrl: STEP_W too narrow for NBYTES");
      end
   endgenerate

   assign busy = run_q;
   assign step = step_q;
   assign last = run_q && (step_q == STEP_W'(NBYTES - 1));
   assign done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         step_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!run_q) begin
            if (start) begin
               run_q  <= 1'b1;
               step_q <= '0;
            end
         end else if (last) begin
            run_q  <= 1'b0;
            step_q <= '0;
            done_q <= 1'b1;
         end else begin
            step_q <= step_q + STEP_W'(1);
         end
      end
   end

   AST_DONE_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R9

   AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy)) else $error("done not after run"); // R9

endmodule

// File: rtl/stk_addr_calc.sv
module stk_addr_calc #(
   parameter int AW     = 16,
   parameter int DW     = 8,
   parameter int NBYTES = 2,
   parameter int STEP_W = 1
) (
   input  logic [AW-1:0]     sp_base,
   input  logic              store,
   input  logic [STEP_W-1:0] step,
   input  logic [AW-1:0]     word,
   output logic [AW-1:0]     addr,
   output logic [DW-1:0]     wdata,
   output logic [AW-1:0]     sp_next
);

   logic [DW-1:0]     lane [NBYTES];
   logic [STEP_W-1:0] sel;

   // Split the word to be stored into byte lanes, lane 0 least significant
   genvar gi;
   generate
      for (gi = 0; gi < NBYTES; gi++) begin : g_lane
         assign lane[gi] = word[gi*DW +: DW];
      end
   endgenerate

   // Stores go from the top lane down, loads from lane 0 up
   assign sel   = STEP_W'(NBYTES - 1) - step;
   assign wdata = lane[sel];

   always_comb begin
      if (store) begin
         addr    = sp_base - AW'(step) - AW'(1);
         sp_next = sp_base - AW'(NBYTES);
      end else begin
         addr    = sp_base + AW'(step);
         sp_next = sp_base + AW'(NBYTES);
      end
   end

endmodule

// File: rtl/stk_pop_collect.sv
module stk_pop_collect #(
   parameter int AW     = 16,
   parameter int DW     = 8,
   parameter int NBYTES = 2,
   parameter int STEP_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [STEP_W-1:0] step,
   input  logic [DW-1:0]     rdata,
   output logic [AW-1:0]     word
);

   // The last lane is taken straight from the bus so the word is whole
   // in the final access cycle; earlier lanes are held in registers.
   genvar gi;
   generate
      for (gi = 0; gi < NBYTES; gi++) begin : g_lane
         if (gi == NBYTES - 1) begin : g_live
            assign word[gi*DW +: DW] = rdata;
         end else begin : g_held
            logic [DW-1:0] lane_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  lane_q <= '0;
               end else if (capture && (step == STEP_W'(gi))) begin
                  lane_q <= rdata;
               end
            end
            assign word[gi*DW +: DW] = lane_q;
         end
      end
   endgenerate

endmodule

// File: rtl/stack_seq_unit.sv
module stack_seq_unit
   import stack_seq_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int VEC_IDX_W = 3,
   parameter int VEC_SHIFT = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_op,
   input  logic [VEC_IDX_W-1:0] cmd_vec,
   input  logic [AW-1:0]        sp_in,
   input  logic [AW-1:0]        pc_in,
   input  logic [AW-1:0]        pair_in,
   input  logic [AW-1:0]        target_in,
   output logic                 mem_we,
   output logic                 mem_re,
   output logic [AW-1:0]        mem_addr,
   output logic [DW-1:0]        mem_wdata,
   input  logic [DW-1:0]        mem_rdata,
   output logic                 busy,
   output logic                 done,
   output logic [AW-1:0]        sp_out,
   output logic [AW-1:0]        pc_out,
   output logic [AW-1:0]        pair_out
);

   localparam int NBYTES = AW / DW;
   localparam int STEP_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   generate
      if ((AW % DW) != 0) begin : g_bad_ratio
         $error("stack_seq_unit: AW must be a multiple of DW");
      end
      if (NBYTES < 2) begin : g_bad_nbytes
         $error("stack_seq_unit: a word must span at least two bytes");
      end
      if ((VEC_IDX_W + VEC_SHIFT) > AW) begin : g_bad_vec
         $error("stack_seq_unit: restart vector does not fit the address");
      end
   endgenerate

   // Operands captured at acceptance
   stk_op_e     op_q;
   logic [AW-1:0] sp_q, pc_q, pair_q, dest_q;

   logic              start, last, store;
   logic [STEP_W-1:0] step;
   logic [AW-1:0]     push_word, pop_word, sp_next, addr;
   logic [DW-1:0]     wdata;

   assign start     = cmd_valid && !busy && op_known(cmd_op);
   assign store     = op_stores(op_q);
   assign push_word = (op_q == OP_PUSH) ? pair_q : pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_NONE;
         sp_q   <= '0;
         pc_q   <= '0;
         pair_q <= '0;
         dest_q <= '0;
      end else if (start) begin
         op_q   <= stk_op_e'(cmd_op);
         sp_q   <= sp_in;
         pc_q   <= pc_in;
         pair_q <= pair_in;
         dest_q <= (stk_op_e'(cmd_op) == OP_RST) ? (AW'(cmd_vec) << VEC_SHIFT) : target_in;
      end
   end

   stk_step_ctrl #(
      .NBYTES (NBYTES),
      .STEP_W (STEP_W)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .step  (step),
      .last  (last),
      .done  (done)
   );

   stk_addr_calc #(
      .AW     (AW),
      .DW     (DW),
      .NBYTES (NBYTES),
      .STEP_W (STEP_W)
   ) u_addr (
      .sp_base (sp_q),
      .store   (store),
      .step    (step),
      .word    (push_word),
      .addr    (addr),
      .wdata   (wdata),
      .sp_next (sp_next)
   );

   stk_pop_collect #(
      .AW     (AW),
      .DW     (DW),
      .NBYTES (NBYTES),
      .STEP_W (STEP_W)
   ) u_collect (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (mem_re),
      .step    (step),
      .rdata   (mem_rdata),
      .word    (pop_word)
   );

   assign mem_we    = busy && store;
   assign mem_re    = busy && !store;
   assign mem_addr  = addr;
   assign mem_wdata = wdata;

   // Results are registered once, at the edge that ends the last access
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_out   <= '0;
         pc_out   <= '0;
         pair_out <= '0;
      end else if (last) begin
         sp_out <= sp_next;
         unique case (op_q)
            OP_CALL, OP_RST: begin
               pc_out   <= dest_q;
               pair_out <= pair_q;
            end
            OP_RET: begin
               pc_out   <= pop_word;
               pair_out <= pair_q;
            end
            OP_POP: begin
               pc_out   <= pc_q;
               pair_out <= pop_word;
            end
            default: begin
               pc_out   <= pc_q;
               pair_out <= pair_q;
            end
         endcase
      end
   end

   AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re)) else $error("read and write together"); // R12

   AST_ACCESS_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> busy) else $error("access outside run"); // R9

   AST_STORE_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)))
      else $error("store order broken"); // R2

   AST_LOAD_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + AW'(1)))
      else $error("load order broken"); // R5

   AST_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && store) |-> (sp_out == sp_q - AW'(NBYTES)))
      else $error("stack pointer not lowered"); // R4

   AST_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !store) |-> (sp_out == sp_q + AW'(NBYTES)))
      else $error("stack pointer not raised"); // R7

   AST_BAD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && !op_known(cmd_op)) |=> !busy)
      else $error("unknown code started a run"); // R11

   AST_RUN_HOLDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(op_q) && $stable(sp_q)))
      else $error("operands changed mid-run"); // R10

endmodule

// File: tb/stack_seq_unit_tb_top.sv
`timescale 1ns/1ps
module stack_seq_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [2:0]  cmd_vec = 3'd0;
   logic [15:0] sp_in = '0, pc_in = '0, pair_in = '0, target_in = '0;
   logic        mem_we, mem_re, busy, done;
   logic [15:0] mem_addr, sp_out, pc_out, pair_out;
   logic [7:0]  mem_wdata, mem_rdata;

   logic [7:0]  mem [256];
   int          n_cmp = 0;
   int          n_bad = 0;
   int          cycles = 0;

   always #10 clk = ~clk;   // 50 MHz

   assign mem_rdata = mem[mem_addr[7:0]];

   stack_seq_unit dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_vec   (cmd_vec),
      .sp_in     (sp_in),
      .pc_in     (pc_in),
      .pair_in   (pair_in),
      .target_in (target_in),
      .mem_we    (mem_we),
      .mem_re    (mem_re),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .busy      (busy),
      .done      (done),
      .sp_out    (sp_out),
      .pc_out    (pc_out),
      .pair_out  (pair_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // One access cycle: check strobes, address and data; model the write
   task automatic check_access(input string req, input bit st,
                               input logic [15:0] exp_addr, input logic [7:0] exp_data);
      chk({req, " busy"}, busy, 1'b1);
      chk({req, " we"}, mem_we, st);
      chk({req, " re"}, mem_re, !st);
      chk({req, " addr"}, mem_addr, exp_addr);
      if (st) begin
         chk({req, " wdata"}, mem_wdata, exp_data);
         mem[mem_addr[7:0]] = mem_wdata;
      end
   endtask

   task automatic run_seq(input logic [2:0] op, input logic [15:0] sp, input logic [15:0] pc,
                          input logic [15:0] pair, input logic [15:0] tgt, input logic [2:0] vec,
                          input logic [15:0] pop_val, input bit preload, input bit disturb);
      bit          st;
      string       rq;
      logic [15:0] pw, a0, a1, exp_sp, exp_pc, exp_pair;
      st = (op == 3'd1) || (op == 3'd3) || (op == 3'd4);
      pw = (op == 3'd4) ? pair : pc;
      a0 = st ? sp - 16'd1 : sp;
      a1 = st ? sp - 16'd2 : sp + 16'd1;
      exp_sp = st ? sp - 16'd2 : sp + 16'd2;
      case (op)
         3'd1: begin rq = "R2"; exp_pc = tgt; end
         3'd2: begin rq = "R5"; exp_pc = pop_val; end
         3'd3: begin rq = "R8"; exp_pc = {10'd0, vec, 3'd0}; end
         3'd4: begin rq = "R3"; exp_pc = pc; end
         default: begin rq = "R6"; exp_pc = pc; end
      endcase
      exp_pair = (op == 3'd5) ? pop_val : pair;
      if (!st && preload) begin
         mem[a0[7:0]] = pop_val[7:0];
         mem[a1[7:0]] = pop_val[15:8];
      end
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_vec = vec;
      sp_in = sp; pc_in = pc; pair_in = pair; target_in = tgt;
      @(negedge clk);
      if (disturb) begin
         cmd_op = 3'd5; cmd_vec = ~vec;
         sp_in = ~sp; pc_in = ~pc; pair_in = ~pair; target_in = ~tgt;
      end else begin
         cmd_valid = 1'b0;
      end
      check_access({rq, " step0"}, st, a0, pw[15:8]);
      @(negedge clk);
      check_access({rq, " step1"}, st, a1, pw[7:0]);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R9 done high", done, 1'b1);
      chk("R9 busy low at done", busy, 1'b0);
      chk("R9 no access at done", {mem_we, mem_re}, 2'b00);
      chk(st ? "R4 sp_out" : "R7 sp_out", sp_out, exp_sp);
      chk({rq, " pc_out"}, pc_out, exp_pc);
      chk({rq, " pair_out"}, pair_out, exp_pair);
      @(negedge clk);
      chk(disturb ? "R10 no second run" : "R9 idle after done", busy, 1'b0);
      chk("R9 done one cycle", done, 1'b0);
      chk("R9 outputs held", sp_out, exp_sp);
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
         end
      end
   end

   initial begin : main
      logic [15:0] sps [6];
      logic [15:0] pat;
      sps[0] = 16'h0000; sps[1] = 16'h0001; sps[2] = 16'h0002;
      sps[3] = 16'h8000; sps[4] = 16'hFFFF; sps[5] = 16'h1234;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;

      // R1: state during and right after reset
      repeat (2) @(negedge clk);
      chk("R1 busy", busy, 1'b0);
      chk("R1 done", done, 1'b0);
      chk("R1 strobes", {mem_we, mem_re}, 2'b00);
      chk("R1 sp_out", sp_out, 16'h0000);
      chk("R1 pc_out", pc_out, 16'h0000);
      chk("R1 pair_out", pair_out, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after release", busy, 1'b0);
      chk("R1 done after release", done, 1'b0);

      // Sweep all commands over the stack pointer corners and two patterns
      for (int s = 0; s < 6; s++) begin
         for (int p = 0; p < 2; p++) begin
            pat = (p == 0) ? 16'hA15C : 16'h3E87;
            for (int op = 1; op <= 5; op++) begin
               run_seq(3'(op), sps[s], pat ^ 16'h0F0F, pat, pat ^ 16'hFFFF, 3'(s),
                       pat ^ 16'h5AA5, 1'b1, 1'b0);
            end
         end
      end

      // R8: every restart vector, target ignored
      for (int v = 0; v < 8; v++) begin
         run_seq(3'd3, 16'h4000 + 16'(v), 16'h2468, 16'h1357, 16'hBEEF, 3'(v),
                 16'h0000, 1'b0, 1'b0);
      end

      // R3/R6 round trip: pushed pair comes back unchanged
      run_seq(3'd4, 16'h0001, 16'h0100, 16'hC0DE, 16'h0000, 3'd0, 16'h0000, 1'b0, 1'b0);
      run_seq(3'd5, 16'hFFFF, 16'h0200, 16'h0000, 16'h0000, 3'd0, 16'hC0DE, 1'b0, 1'b0);
      // R2/R5 round trip: call then return restores the following address
      run_seq(3'd1, 16'h9000, 16'h7B3A, 16'h1111, 16'h0400, 3'd0, 16'h0000, 1'b0, 1'b0);
      run_seq(3'd2, 16'h8FFE, 16'h0401, 16'h1111, 16'h0000, 3'd0, 16'h7B3A, 1'b0, 1'b0);

      // R10: commands held during a run are ignored
      run_seq(3'd1, 16'h2000, 16'h1234, 16'h5678, 16'h9ABC, 3'd2, 16'h0000, 1'b0, 1'b1);
      run_seq(3'd5, 16'h3000, 16'h4321, 16'h8765, 16'h0000, 3'd1, 16'hF00D, 1'b1, 1'b1);

      // R11: unused codes do nothing
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         cmd_valid = 1'b1;
         cmd_op = (k == 0) ? 3'd0 : 3'(5 + k);
         sp_in = 16'h7777;
         @(negedge clk);
         cmd_valid = 1'b0;
         for (int c = 0; c < 3; c++) begin
            chk("R11 no busy", busy, 1'b0);
            chk("R11 no access", {mem_we, mem_re}, 2'b00);
            chk("R11 no done", done, 1'b0);
            @(negedge clk);
         end
         chk("R11 sp_out unchanged", sp_out, 16'h3002);
      end

      finish_run();
   end

endmodule